// File: doc/BRIEF.md
# Line Run Splitter

This block turns a straight line, given as two signed endpoints, into a stream of axis-aligned rectangle fill commands. Each command covers one maximal run of pixels that share a minor-axis coordinate, so a fill engine that paints a whole rectangle per write needs only min(|dx|,|dy|)+1 writes for the line. The pixels covered are exactly those of a conventional incremental integer line walk.

A line is started with a one-cycle `start_i` pulse while the block is idle. Rectangles leave through a valid/ready stream, each as an inclusive lower-left / upper-right corner pair, in order from the first endpoint toward the second. After the final rectangle has been accepted, `done_o` pulses for one cycle and the block takes a new line.

Top module: `line_run_splitter`

## Requirements
- R1: A line with endpoint differences dx, dy produces exactly min(|dx|,|dy|)+1 rectangles, followed by a single `done_o` pulse.
- R2: When dy = 0 or dx = 0 (but not both), exactly one rectangle is produced, one pixel thick, spanning both endpoints.
- R3: When |dx| = |dy| > 0, |dx|+1 rectangles are produced, each 1x1, on the diagonal from the first endpoint to the second.
- R4: Each rectangle is given by inclusive corners with lower-left x <= upper-right x and lower-left y <= upper-right y, whatever the line direction.
- R5: The major axis is x when |dx| >= |dy|, otherwise y. With M the major length and m the minor length, pixel k (k = 0..M) lies at major coordinate start + k toward the end, and minor coordinate start + floor((2km + M) / (2M)) toward the end; the union of the rectangles is exactly this pixel set.
- R6: Rectangles are emitted in order from the first endpoint; each is one pixel thick across the major axis, consecutive ones are adjacent along the major axis with no overlap, and their minor coordinate changes by exactly one.
- R7: While `rect_valid_o` is high and `rect_ready_i` is low, `rect_valid_o` and all four corner outputs hold their values.
- R8: A `start_i` pulse arriving after a line has been accepted and before its `done_o` pulse is ignored; the running line's output is unchanged.
- R9: A zero-length line (both endpoints equal) produces one 1x1 rectangle at that point.
- R10: `done_o` is high for exactly one cycle, never together with `rect_valid_o`, and only after the last rectangle has been accepted.
- R11: After reset, `rect_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a line using the endpoint inputs (taken only when idle) |
| x0_i | input | CW | First endpoint x, signed |
| y0_i | input | CW | First endpoint y, signed |
| x1_i | input | CW | Second endpoint x, signed |
| y1_i | input | CW | Second endpoint y, signed |
| rect_valid_o | output | 1 | A rectangle command is presented |
| rect_ready_i | input | 1 | Consumer takes the command this cycle |
| ll_x_o | output | CW | Lower-left x, signed, inclusive |
| ll_y_o | output | CW | Lower-left y, signed, inclusive |
| ur_x_o | output | CW | Upper-right x, signed, inclusive |
| ur_y_o | output | CW | Upper-right y, signed, inclusive |
| done_o | output | 1 | One-cycle pulse once the whole line has been handed over |

## Verification
The assertions assume the consumer obeys the stream contract, so a command is only taken on a cycle where `rect_ready_i` is high, and that endpoint differences fit the signed coordinate width. The stimulus keeps every endpoint well inside the 12-bit signed range and changes `rect_ready_i` only between clock edges, from either an always-ready pattern or a pseudo-random one. Stray `start_i` pulses are only driven while a line is in flight, which is the situation the ignore rule covers.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_DRAIN = 2'd2
  } lrs_state_e;
endpackage

// File: rtl/lrs_setup.sv
// Per-line geometry: major axis choice, lengths, step directions, start point.
module lrs_setup #(
  parameter int CW = 12
) (
  input  logic signed [CW-1:0] x0_i,
  input  logic signed [CW-1:0] y0_i,
  input  logic signed [CW-1:0] x1_i,
  input  logic signed [CW-1:0] y1_i,
  output logic                 x_major_o,
  output logic        [CW:0]   maj_len_o,
  output logic        [CW:0]   min_len_o,
  output logic                 maj_neg_o,
  output logic                 min_neg_o,
  output logic signed [CW-1:0] maj0_o,
  output logic signed [CW-1:0] min0_o
);
  logic signed [CW:0] dx, dy;
  logic        [CW:0] adx, ady;

  always_comb begin
    dx  = {x1_i[CW-1], x1_i} - {x0_i[CW-1], x0_i};
    dy  = {y1_i[CW-1], y1_i} - {y0_i[CW-1], y0_i};
    adx = dx[CW] ? $unsigned(-dx) : $unsigned(dx);
    ady = dy[CW] ? $unsigned(-dy) : $unsigned(dy);
    x_major_o = (adx >= ady);
    if (x_major_o) begin
      maj_len_o = adx;
      min_len_o = ady;
      maj_neg_o = dx[CW];
      min_neg_o = dy[CW];
      maj0_o    = x0_i;
      min0_o    = y0_i;
    end else begin
      maj_len_o = ady;
      min_len_o = adx;
      maj_neg_o = dy[CW];
      min_neg_o = dx[CW];
      maj0_o    = y0_i;
      min0_o    = x0_i;
    end
  end
endmodule

// File: rtl/lrs_stepper.sv
// Error term: r_k = (2km + M) mod 2M; wrap_o flags a minor step on the next major step.
module lrs_stepper #(
  parameter int LW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [LW-1:0] maj_len_i,
  input  logic [LW-1:0] min_len_i,
  output logic          last_o,
  output logic          wrap_o
);
  localparam int RW = LW + 2;

  logic [LW-1:0] maj_len_q, min_len_q, k_q;
  logic [RW-1:0] r_q, sum, two_maj;

  always_comb begin
    sum     = r_q + {1'b0, min_len_q, 1'b0};
    two_maj = {1'b0, maj_len_q, 1'b0};
    wrap_o  = (sum >= two_maj);
    last_o  = (k_q == maj_len_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maj_len_q <= '0;
      min_len_q <= '0;
      k_q       <= '0;
      r_q       <= '0;
    end else if (load_i) begin
      maj_len_q <= maj_len_i;
      min_len_q <= min_len_i;
      k_q       <= '0;
      r_q       <= {2'b00, maj_len_i};
    end else if (step_i) begin
      k_q <= k_q + 1'b1;
      r_q <= wrap_o ? (sum - two_maj) : sum;
    end
  end
endmodule

// File: rtl/lrs_rect_slot.sv
// Output register: maps major/minor run back to x/y and orders the corners.
module lrs_rect_slot #(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 x_major_i,
  input  logic signed [CW-1:0] run_a_i,
  input  logic signed [CW-1:0] run_b_i,
  input  logic signed [CW-1:0] minc_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic signed [CW-1:0] ll_x_o,
  output logic signed [CW-1:0] ll_y_o,
  output logic signed [CW-1:0] ur_x_o,
  output logic signed [CW-1:0] ur_y_o
);
  logic signed [CW-1:0] lo, hi;

  always_comb begin
    lo = (run_a_i <= run_b_i) ? run_a_i : run_b_i;
    hi = (run_a_i <= run_b_i) ? run_b_i : run_a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ll_x_o  <= '0;
      ll_y_o  <= '0;
      ur_x_o  <= '0;
      ur_y_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      if (x_major_i) begin
        ll_x_o <= lo;
        ur_x_o <= hi;
        ll_y_o <= minc_i;
        ur_y_o <= minc_i;
      end else begin
        ll_y_o <= lo;
        ur_y_o <= hi;
        ll_x_o <= minc_i;
        ur_x_o <= minc_i;
      end
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/line_run_splitter.sv
module line_run_splitter #(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [CW-1:0] x0_i,
  input  logic signed [CW-1:0] y0_i,
  input  logic signed [CW-1:0] x1_i,
  input  logic signed [CW-1:0] y1_i,
  output logic                 rect_valid_o,
  input  logic                 rect_ready_i,
  output logic signed [CW-1:0] ll_x_o,
  output logic signed [CW-1:0] ll_y_o,
  output logic signed [CW-1:0] ur_x_o,
  output logic signed [CW-1:0] ur_y_o,
  output logic                 done_o
);
  import lrs_pkg::*;

  localparam int LW = CW + 1;
  localparam logic signed [CW-1:0] ONE_C = 1;

  lrs_state_e state_q;

  logic                 s_x_major, s_maj_neg, s_min_neg;
  logic        [LW-1:0] s_maj_len, s_min_len;
  logic signed [CW-1:0] s_maj0, s_min0;

  logic                 x_major_q, maj_neg_q, min_neg_q, done_q;
  logic signed [CW-1:0] cur_maj_q, cur_min_q, run_start_q;
  logic signed [CW-1:0] nxt_maj, nxt_min;

  logic accept, adv, walk_adv, last, wrap, emit, step;

  lrs_setup #(.CW(CW)) u_setup (
    .x0_i      (x0_i),
    .y0_i      (y0_i),
    .x1_i      (x1_i),
    .y1_i      (y1_i),
    .x_major_o (s_x_major),
    .maj_len_o (s_maj_len),
    .min_len_o (s_min_len),
    .maj_neg_o (s_maj_neg),
    .min_neg_o (s_min_neg),
    .maj0_o    (s_maj0),
    .min0_o    (s_min0)
  );

  always_comb begin
    accept   = start_i && (state_q == ST_IDLE);
    adv      = !rect_valid_o || rect_ready_i;  // slot free after this edge
    walk_adv = (state_q == ST_WALK) && adv;
    emit     = walk_adv && (last || wrap);
    step     = walk_adv && !last;
    nxt_maj  = maj_neg_q ? (cur_maj_q - ONE_C) : (cur_maj_q + ONE_C);
    nxt_min  = min_neg_q ? (cur_min_q - ONE_C) : (cur_min_q + ONE_C);
  end

  lrs_stepper #(.LW(LW)) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .step_i    (step),
    .maj_len_i (s_maj_len),
    .min_len_i (s_min_len),
    .last_o    (last),
    .wrap_o    (wrap)
  );

  lrs_rect_slot #(.CW(CW)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (emit),
    .x_major_i (x_major_q),
    .run_a_i   (run_start_q),
    .run_b_i   (cur_maj_q),
    .minc_i    (cur_min_q),
    .ready_i   (rect_ready_i),
    .valid_o   (rect_valid_o),
    .ll_x_o    (ll_x_o),
    .ll_y_o    (ll_y_o),
    .ur_x_o    (ur_x_o),
    .ur_y_o    (ur_y_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      x_major_q   <= 1'b0;
      maj_neg_q   <= 1'b0;
      min_neg_q   <= 1'b0;
      cur_maj_q   <= '0;
      cur_min_q   <= '0;
      run_start_q <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q     <= ST_WALK;
          x_major_q   <= s_x_major;
          maj_neg_q   <= s_maj_neg;
          min_neg_q   <= s_min_neg;
          cur_maj_q   <= s_maj0;
          cur_min_q   <= s_min0;
          run_start_q <= s_maj0;
        end
        ST_WALK: if (walk_adv) begin
          if (last) begin
            state_q <= ST_DRAIN;
          end else begin
            cur_maj_q <= nxt_maj;
            if (wrap) begin
              cur_min_q   <= nxt_min;
              run_start_q <= nxt_maj;
            end
          end
        end
        ST_DRAIN: if (adv) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int CW = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rect_valid_o,
  input logic                 rect_ready_i,
  input logic signed [CW-1:0] ll_x_o,
  input logic signed [CW-1:0] ll_y_o,
  input logic signed [CW-1:0] ur_x_o,
  input logic signed [CW-1:0] ur_y_o,
  input logic                 done_o
);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rect_valid_o && !rect_ready_i |=> rect_valid_o && $stable(ll_x_o) && $stable(ll_y_o)
                                      && $stable(ur_x_o) && $stable(ur_y_o));

  assert_corner_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rect_valid_o |-> (ll_x_o <= ur_x_o) && (ll_y_o <= ur_y_o));

  assert_thin_run_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rect_valid_o |-> (ll_x_o == ur_x_o) || (ll_y_o == ur_y_o));

  assert_done_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rect_valid_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind line_run_splitter lrs_checker #(.CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rect_valid_o (rect_valid_o),
  .rect_ready_i (rect_ready_i),
  .ll_x_o       (ll_x_o),
  .ll_y_o       (ll_y_o),
  .ur_x_o       (ur_x_o),
  .ur_y_o       (ur_y_o),
  .done_o       (done_o)
);

// File: tb/sim_line_run_splitter.sv
module sim_line_run_splitter;
  localparam int CW = 12;
  localparam int MAXR = 600;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic signed [CW-1:0] x0_i = '0, y0_i = '0, x1_i = '0, y1_i = '0;
  logic rect_ready_i = 1'b0;
  logic rect_valid_o, done_o;
  logic signed [CW-1:0] ll_x_o, ll_y_o, ur_x_o, ur_y_o;

  int total = 0;
  int bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  int exp_n;
  int e_llx [MAXR];
  int e_lly [MAXR];
  int e_urx [MAXR];
  int e_ury [MAXR];

  always #4 clk = ~clk;

  line_run_splitter #(.CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .x0_i(x0_i), .y0_i(y0_i), .x1_i(x1_i), .y1_i(y1_i),
    .rect_valid_o(rect_valid_o), .rect_ready_i(rect_ready_i),
    .ll_x_o(ll_x_o), .ll_y_o(ll_y_o), .ur_x_o(ur_x_o), .ur_y_o(ur_y_o),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference pixel walk, grouped into runs of equal minor coordinate.
  task automatic build_ref(input int x0, input int y0, input int x1, input int y1);
    int dx = x1 - x0;
    int dy = y1 - y0;
    int adx = dx < 0 ? -dx : dx;
    int ady = dy < 0 ? -dy : dy;
    bit xm = (adx >= ady);
    int mj = xm ? adx : ady;
    int mn = xm ? ady : adx;
    int smj = xm ? (dx < 0 ? -1 : 1) : (dy < 0 ? -1 : 1);
    int smn = xm ? (dy < 0 ? -1 : 1) : (dx < 0 ? -1 : 1);
    int mj0 = xm ? x0 : y0;
    int mn0 = xm ? y0 : x0;
    int prev = -1;
    int ra = 0, rb = 0, rm = 0;
    exp_n = 0;
    for (int k = 0; k <= mj; k++) begin
      int off = (mj == 0) ? 0 : (2 * k * mn + mj) / (2 * mj);
      int pmj = mj0 + smj * k;
      if (off != prev) begin
        if (prev >= 0) begin
          e_llx[exp_n] = xm ? (ra < rb ? ra : rb) : rm;
          e_urx[exp_n] = xm ? (ra < rb ? rb : ra) : rm;
          e_lly[exp_n] = xm ? rm : (ra < rb ? ra : rb);
          e_ury[exp_n] = xm ? rm : (ra < rb ? rb : ra);
          exp_n++;
        end
        ra = pmj;
        rm = mn0 + smn * off;
        prev = off;
      end
      rb = pmj;
    end
    e_llx[exp_n] = xm ? (ra < rb ? ra : rb) : rm;
    e_urx[exp_n] = xm ? (ra < rb ? rb : ra) : rm;
    e_lly[exp_n] = xm ? rm : (ra < rb ? ra : rb);
    e_ury[exp_n] = xm ? rm : (ra < rb ? rb : ra);
    exp_n++;
  endtask

  // bp: 0 always ready, 1 pseudo-random ready. poke: stray start while busy.
  task automatic run_line(input string req, input int x0, input int y0, input int x1, input int y1,
                          input int bp, input bit poke);
    int got = 0;
    int cyc = 0;
    bit fin = 0;
    bit pv = 0;
    bit pr = 0;
    int p_llx = 0, p_lly = 0, p_urx = 0, p_ury = 0;
    int dx = x1 - x0;
    int dy = y1 - y0;
    int adx = dx < 0 ? -dx : dx;
    int ady = dy < 0 ? -dy : dy;
    int mins = adx < ady ? adx : ady;
    build_ref(x0, y0, x1, y1);
    @(negedge clk);
    x0_i = x0[CW-1:0]; y0_i = y0[CW-1:0]; x1_i = x1[CW-1:0]; y1_i = y1[CW-1:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!fin && cyc < 5000) begin
      cyc++;
      if (poke && cyc == 3) begin
        x0_i = 12'sd100; y0_i = -12'sd50; x1_i = -12'sd7; y1_i = 12'sd300;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (pv && !pr) begin
        check(rect_valid_o && $signed(ll_x_o) == p_llx && $signed(ll_y_o) == p_lly &&
              $signed(ur_x_o) == p_urx && $signed(ur_y_o) == p_ury,
              "R7", "held command changed, ll_x", int'($signed(ll_x_o)), p_llx);
      end
      if (bp == 0) rect_ready_i = 1'b1;
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rect_ready_i = lfsr[0] | lfsr[3];
      end
      if (done_o) begin
        check(!rect_valid_o, "R10", "valid during done", int'(rect_valid_o), 0);
        check(got == exp_n, {req, " R1"}, "rectangle count", got, exp_n);
        check(got == mins + 1, "R1", "count vs min+1", got, mins + 1);
        fin = 1;
      end else if (rect_valid_o && rect_ready_i) begin
        if (got < MAXR && got < exp_n) begin
          check($signed(ll_x_o) == e_llx[got] && $signed(ur_x_o) == e_urx[got],
                {req, " R5 R6"}, "x corners (ll_x)", int'($signed(ll_x_o)), e_llx[got]);
          check($signed(ll_y_o) == e_lly[got] && $signed(ur_y_o) == e_ury[got],
                {req, " R5 R4"}, "y corners (ll_y)", int'($signed(ll_y_o)), e_lly[got]);
        end else begin
          check(0, "R1", "extra rectangle index", got, exp_n - 1);
        end
        got++;
      end
      pv = rect_valid_o; pr = rect_ready_i;
      p_llx = $signed(ll_x_o); p_lly = $signed(ll_y_o);
      p_urx = $signed(ur_x_o); p_ury = $signed(ur_y_o);
      if (!fin) @(negedge clk);
    end
    start_i = 1'b0;
    if (!fin) check(0, req, "line never finished, rects", got, exp_n);
    else begin
      @(negedge clk);
      check(!done_o && !rect_valid_o, "R10", "done not a single pulse", int'(done_o), 0);
      if (poke) check(!rect_valid_o, "R8", "stray start produced output", int'(rect_valid_o), 0);
    end
    rect_ready_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!rect_valid_o, "R11", "valid after reset", int'(rect_valid_o), 0);
    check(!done_o, "R11", "done after reset", int'(done_o), 0);
  endtask

  task automatic t_axis();
    run_line("R2", -5, 3, 20, 3, 0, 0);
    check(exp_n == 1 && e_llx[0] == -5 && e_urx[0] == 20, "R2", "ref horizontal", exp_n, 1);
    run_line("R2", 4, 9, 4, -30, 1, 0);
    run_line("R2", 30, -2, 0, -2, 1, 0);
  endtask

  task automatic t_diag();
    run_line("R3", 0, 0, 7, 7, 0, 0);
    run_line("R3", 10, -3, 2, 5, 1, 0);
    run_line("R3", -1, -1, -9, -9, 0, 0);
  endtask

  task automatic t_zero();
    run_line("R9", 17, -23, 17, -23, 0, 0);
    run_line("R9", 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_general();
    run_line("R5", 0, 0, 13, 4, 0, 0);
    run_line("R5", 3, 2, -20, 9, 1, 0);
    run_line("R5", -4, 8, 2, -27, 0, 0);
    run_line("R5", 5, 5, 8, 40, 1, 0);
    run_line("R6", -100, 50, 150, -11, 1, 0);
    run_line("R6", 7, 1, 6, 3, 0, 0);
  endtask

  task automatic t_backpressure();
    run_line("R7", 1, 1, 40, 17, 1, 0);
    run_line("R7", -300, 200, 100, -10, 1, 0);
  endtask

  task automatic t_busy_start();
    run_line("R8", 0, 0, 25, 6, 1, 1);
    run_line("R8", 2, 2, 2, 40, 0, 1);
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", "cycles expired", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_axis();
    t_diag();
    t_zero();
    t_general();
    t_backpressure();
    t_busy_start();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule